// File: doc/BRIEF.md
# Double-Buffered Toggle Pulse Generator

This block produces a programmable rectangular waveform from a 16-bit up-counter and two compare values. One compare value marks the point inside each cycle where the output changes level (the duty point), and the other marks the last count of the cycle (the period). The output flip-flop inverts on either match. The period match also sends the counter back to zero and raises a one-cycle interrupt pulse. The result is a waveform whose level flips twice per counter cycle. The duty value must stay below the period value for that to hold.

Software sets the block up through a small write-only register port. It writes the duty value, the period value and a control word. The control word holds a run bit, a buffering enable, a toggle enable and a command that clears the output. Counting advances only on cycles where an external prescaler enable is high.

With buffering on, new duty and period values wait in shadow registers. Both copy into the active compare registers together at the period match. This lets the waveform change between cycles without a glitch. With buffering off, writes go straight to the active registers.

Top module: `tpg_top`

## Requirements
- R1: After synchronous reset the output is 0 and the interrupt is 0. The counter, both compare values and all control bits are 0, so the block is stopped, unbuffered and not toggling.
- R2: A write with `cfg_addr` 0 sets the duty value and `cfg_addr` 1 sets the period value. `cfg_addr` 2 sets the control word: bit 0 run, bit 1 buffer enable, bit 2 toggle enable, bit 3 clear-output command. A write takes effect on the following cycle.
- R3: While running, the counter advances by one on each cycle where `tick_en` is high. It holds its value on cycles where `tick_en` is low.
- R4: On a tick cycle where the counter equals the active period value, the counter becomes 0 on the next cycle. One waveform cycle therefore spans period + 1 ticks.
- R5: `period_irq` is high exactly on those running tick cycles where the counter equals the active period value, so it is a single-cycle pulse per match.
- R6: With toggle enabled, `pulse_out` inverts on the cycle after a running tick cycle where the counter equals the duty value, and again on the cycle after a period match. If duty equals period, the two inversions cancel and the level holds. With toggle disabled, the level holds.
- R7: Writing the control word with bit 3 set forces `pulse_out` to 0 on the next cycle. This overrides any inversion in that cycle. The bit is a command and is not stored.
- R8: With buffering disabled, duty and period writes load the active compare values directly.
- R9: With buffering enabled, duty and period writes load only the shadow values. Both shadows copy into the active values at the period-match cycle (the cycle `period_irq` is high) and take effect on the next cycle.
- R10: While the run bit is 0, the counter is forced to 0 and held there, and `pulse_out` keeps its level apart from the clear command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select: 0 duty, 1 period, 2 control |
| cfg_wdata | input | 16 | Write data |
| tick_en | input | 1 | Prescaled count enable |
| pulse_out | output | 1 | Toggle flip-flop output |
| period_irq | output | 1 | One-cycle period-match interrupt pulse |

## Verification
The bench first runs with `tick_en` held high, using a short period and a mid-cycle duty value. This shows the exact spacing of the toggles and the interrupt pulse. An alternating `tick_en` pattern then shows that the counter stalls rather than skipping counts.

Later patterns separate the remaining controls. A clear command is issued mid-cycle, and a run with toggling disabled follows. Stopping mid-cycle checks that the level is held. A buffered run loads new values while the old ones are still active, so the moment the new waveform starts shows when the load happens. Equal duty and period values check that two coincident inversions cancel.

// File: rtl/tpg_pkg.sv
package tpg_pkg;

    // register select codes on the configuration port
    typedef enum logic [1:0] {
        SEL_DUTY   = 2'd0,
        SEL_PERIOD = 2'd1,
        SEL_CTRL   = 2'd2
    } reg_sel_e;

    // control word bit positions
    localparam int unsigned CTL_RUN_BIT = 0;
    localparam int unsigned CTL_BUF_BIT = 1;
    localparam int unsigned CTL_TOG_BIT = 2;
    localparam int unsigned CTL_CLR_BIT = 3;
    localparam int unsigned CTL_BITS    = 4;
    localparam int unsigned NUM_CMP     = 2;

    // decoded control; clr_out is a one-cycle command, never stored
    typedef struct packed {
        logic clr_out;
        logic tog_en;
        logic buf_en;
        logic run;
    } ctrl_t;

    // compare events seen by the toggle stage
    typedef struct packed {
        logic duty_hit;
        logic period_hit;
    } match_t;

    function automatic ctrl_t decode_ctrl(input logic [CTL_BITS-1:0] w);
        ctrl_t c;
        c.run     = w[CTL_RUN_BIT];
        c.buf_en  = w[CTL_BUF_BIT];
        c.tog_en  = w[CTL_TOG_BIT];
        c.clr_out = w[CTL_CLR_BIT];
        return c;
    endfunction

    function automatic logic flip_req(input match_t m);
        // two coincident inversions cancel
        return m.duty_hit ^ m.period_hit;
    endfunction

endpackage

// File: rtl/tpg_regs.sv
module tpg_regs
    import tpg_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  logic [1:0]   addr,
    input  logic [W-1:0] wdata,
    input  logic         reload,
    output logic [W-1:0] duty_act,
    output logic [W-1:0] period_act,
    output ctrl_t        ctrl
);

    logic [W-1:0] act_q [NUM_CMP];
    logic         run_q;
    logic         buf_q;
    logic         tog_q;
    ctrl_t        wr_ctrl;
    logic         ctrl_wr;

    assign ctrl_wr = we && (addr == SEL_CTRL);
    assign wr_ctrl = decode_ctrl(wdata[CTL_BITS-1:0]);

    // one active/shadow pair per compare channel
    for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp
        logic [W-1:0] shadow_q;
        logic         hit_wr;

        assign hit_wr = we && (addr == 2'(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                shadow_q <= '0;
                act_q[i] <= '0;
            end else if (!buf_q) begin
                if (hit_wr) begin
                    shadow_q <= wdata;
                    act_q[i] <= wdata;
                end
            end else begin
                if (hit_wr) begin
                    shadow_q <= wdata;
                end
                if (reload) begin
                    act_q[i] <= shadow_q;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= 1'b0;
            buf_q <= 1'b0;
            tog_q <= 1'b0;
        end else if (ctrl_wr) begin
            run_q <= wr_ctrl.run;
            buf_q <= wr_ctrl.buf_en;
            tog_q <= wr_ctrl.tog_en;
        end
    end

    always_comb begin
        ctrl.run     = run_q;
        ctrl.buf_en  = buf_q;
        ctrl.tog_en  = tog_q;
        ctrl.clr_out = ctrl_wr && wr_ctrl.clr_out;
    end

    assign duty_act   = act_q[int'(SEL_DUTY)];
    assign period_act = act_q[int'(SEL_PERIOD)];

endmodule

// File: rtl/tpg_counter.sv
module tpg_counter
    import tpg_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         tick,
    input  logic [W-1:0] duty,
    input  logic [W-1:0] period,
    output logic [W-1:0] cnt,
    output match_t       hits
);

    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] cnt_q;
    logic         step;

    assign step = run && tick;

    always_comb begin
        hits.duty_hit   = step && (cnt_q == duty);
        hits.period_hit = step && (cnt_q == period);
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else if (tick) begin
            if (hits.period_hit) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + ONE;
            end
        end
    end

    assign cnt = cnt_q;

endmodule

// File: rtl/tpg_toggle.sv
module tpg_toggle
    import tpg_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   tog_en,
    input  logic   clr,
    input  match_t hits,
    output logic   level
);

    logic lvl_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            lvl_q <= 1'b0;
        end else if (tog_en && flip_req(hits)) begin
            lvl_q <= ~lvl_q;
        end
    end

    assign level = lvl_q;

endmodule

// File: rtl/tpg_top.sv
module tpg_top
    import tpg_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cfg_we,
    input  logic [1:0]   cfg_addr,
    input  logic [W-1:0] cfg_wdata,
    input  logic         tick_en,
    output logic         pulse_out,
    output logic         period_irq
);

    logic [W-1:0] duty_act;
    logic [W-1:0] period_act;
    logic [W-1:0] cnt_q;
    ctrl_t        ctrl;
    match_t       hits;

    tpg_regs #(.W(W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .we         (cfg_we),
        .addr       (cfg_addr),
        .wdata      (cfg_wdata),
        .reload     (hits.period_hit),
        .duty_act   (duty_act),
        .period_act (period_act),
        .ctrl       (ctrl)
    );

    tpg_counter #(.W(W)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .run    (ctrl.run),
        .tick   (tick_en),
        .duty   (duty_act),
        .period (period_act),
        .cnt    (cnt_q),
        .hits   (hits)
    );

    tpg_toggle u_tog (
        .clk    (clk),
        .rst    (rst),
        .tog_en (ctrl.tog_en),
        .clr    (ctrl.clr_out),
        .hits   (hits),
        .level  (pulse_out)
    );

    assign period_irq = hits.period_hit;

endmodule

// File: rtl/tpg_checker.sv
module tpg_checker
    import tpg_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         cfg_we,
    input logic [1:0]   cfg_addr,
    input logic [W-1:0] cfg_wdata,
    input logic         tick_en,
    input logic         pulse_out,
    input logic         period_irq,
    input logic [W-1:0] cnt_q,
    input logic [W-1:0] period_act,
    input ctrl_t        ctrl
);

    logic clr_cmd;
    assign clr_cmd = cfg_we && (cfg_addr == SEL_CTRL) && cfg_wdata[CTL_CLR_BIT];

    AST_IRQ_CLEARS_CNT: assert property (@(posedge clk) disable iff (rst)
        period_irq |=> (cnt_q == '0)); // R4

    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
        period_irq |=> (!period_irq || period_act == '0)); // R5

    AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (rst)
        (ctrl.run && !tick_en) |=> $stable(cnt_q)); // R3

    AST_STOP_ZERO: assert property (@(posedge clk) disable iff (rst)
        !ctrl.run |=> (cnt_q == '0)); // R10

    AST_STOP_LEVEL: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.run && !clr_cmd) |=> $stable(pulse_out)); // R10

    AST_CLEAR_CMD: assert property (@(posedge clk) disable iff (rst)
        clr_cmd |=> !pulse_out); // R7

    AST_NO_TOGGLE: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.tog_en && !clr_cmd) |=> $stable(pulse_out)); // R6

    AST_BUF_HOLD: assert property (@(posedge clk) disable iff (rst)
        (ctrl.buf_en && !period_irq) |=> $stable(period_act)); // R9

endmodule

bind tpg_top tpg_checker #(.W(W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cfg_we     (cfg_we),
    .cfg_addr   (cfg_addr),
    .cfg_wdata  (cfg_wdata),
    .tick_en    (tick_en),
    .pulse_out  (pulse_out),
    .period_irq (period_irq),
    .cnt_q      (cnt_q),
    .period_act (period_act),
    .ctrl       (ctrl)
);

// File: tb/tb_tpg_top.sv
module tb_tpg_top;

    localparam int CLK_P = 10;
    localparam int W     = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cfg_we = 1'b0;
    logic [1:0]   cfg_addr = 2'd0;
    logic [W-1:0] cfg_wdata = '0;
    logic         tick_en = 1'b0;
    logic         pulse_out;
    logic         period_irq;

    tpg_top #(.W(W)) dut (
        .clk        (clk),
        .rst        (rst),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .tick_en    (tick_en),
        .pulse_out  (pulse_out),
        .period_irq (period_irq)
    );

    always #(CLK_P/2) clk = ~clk;

    // scoreboard
    logic [1:0] exp_q [$];
    string      tag_q [$];
    int         n_vec  = 0;
    int         n_fail = 0;
    bit         done   = 1'b0;

    // reference state from the requirements
    logic [W-1:0] m_cnt, m_duty_a, m_per_a, m_duty_s, m_per_s;
    logic         m_ff, m_run, m_buf, m_tog;

    task automatic model_reset();
        m_cnt = '0; m_duty_a = '0; m_per_a = '0; m_duty_s = '0; m_per_s = '0;
        m_ff = 1'b0; m_run = 1'b0; m_buf = 1'b0; m_tog = 1'b0;
    endtask

    task automatic step(input logic we, input logic [1:0] a, input logic [W-1:0] d,
                        input logic tk, input string tag);
        logic dm, pm, clr;
        logic [W-1:0] old_ds, old_ps;
        @(negedge clk);
        cfg_we = we; cfg_addr = a; cfg_wdata = d; tick_en = tk;
        dm  = m_run && tk && (m_cnt == m_duty_a);
        pm  = m_run && tk && (m_cnt == m_per_a);
        clr = we && (a == 2'd2) && d[3];
        exp_q.push_back({m_ff, pm});
        tag_q.push_back(tag);
        // next state
        if (clr) m_ff = 1'b0;
        else if (m_tog && (dm ^ pm)) m_ff = ~m_ff;
        if (!m_run) m_cnt = '0;
        else if (tk) m_cnt = pm ? '0 : m_cnt + 1'b1;
        old_ds = m_duty_s; old_ps = m_per_s;
        if (!m_buf) begin
            if (we && a == 2'd0) begin m_duty_a = d; m_duty_s = d; end
            if (we && a == 2'd1) begin m_per_a = d; m_per_s = d; end
        end else begin
            if (pm) begin m_duty_a = old_ds; m_per_a = old_ps; end
            if (we && a == 2'd0) m_duty_s = d;
            if (we && a == 2'd1) m_per_s = d;
        end
        if (we && a == 2'd2) begin
            m_run = d[0]; m_buf = d[1]; m_tog = d[2];
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [W-1:0] d, input string tag);
        step(1'b1, a, d, 1'b1, tag);
    endtask

    task automatic idle(input int n, input int pat, input string tag);
        // pat 0: tick always, 1: alternate, 2: tick never
        for (int i = 0; i < n; i++) begin
            step(1'b0, 2'd0, '0, (pat == 0) ? 1'b1 : (pat == 1) ? logic'(i % 2) : 1'b0, tag);
        end
    endtask

    // monitor
    initial begin
        forever begin
            @(negedge clk);
            #(CLK_P/4);
            if (exp_q.size() > 0) begin
                logic [1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                n_vec++;
                if ({pulse_out, period_irq} !== e) begin
                    n_fail++;
                    $display("FAIL %s: out/irq actual=%b%b expected=%b%b at %0t",
                             t, pulse_out, period_irq, e[1], e[0], $time);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state, stopped, ticks ignored
        idle(4, 0, "R1");
        // R2 R8: direct loads, duty 2 period 5, then run with toggle
        wr(2'd0, 16'd2, "R8");
        wr(2'd1, 16'd5, "R8");
        wr(2'd2, 16'h0005, "R2");
        // R4 R5 R6: continuous ticks, two full periods
        idle(14, 0, "R4_R5_R6");
        // R3: alternating ticks stretch the waveform
        idle(20, 1, "R3");
        idle(5, 2, "R3");
        // R7: clear command mid-cycle while running
        idle(3, 0, "R6");
        wr(2'd2, 16'h000D, "R7");
        idle(8, 0, "R7");
        // R6: toggling disabled, level holds
        wr(2'd2, 16'h0001, "R6");
        idle(12, 0, "R6");
        wr(2'd2, 16'h0005, "R6");
        idle(4, 0, "R6");
        // R10: stop mid-cycle, counter held at 0, level kept
        wr(2'd2, 16'h0004, "R10");
        idle(6, 0, "R10");
        wr(2'd2, 16'h0005, "R10");
        idle(4, 0, "R10");
        // R9: buffered, new values wait for the period match
        wr(2'd2, 16'h0007, "R9");
        wr(2'd0, 16'd1, "R9");
        wr(2'd1, 16'd3, "R9");
        idle(16, 0, "R9");
        wr(2'd1, 16'd7, "R9");
        wr(2'd0, 16'd4, "R9");
        idle(20, 0, "R9");
        // R6: equal duty and period cancel, direct mode
        wr(2'd2, 16'h0004, "R6");
        wr(2'd0, 16'd4, "R6");
        wr(2'd1, 16'd4, "R6");
        wr(2'd2, 16'h0005, "R6");
        idle(12, 0, "R6_R5");
        // R4: period zero, interrupt every tick
        wr(2'd1, 16'd0, "R4");
        wr(2'd0, 16'd0, "R4");
        idle(6, 1, "R4");
        idle(2, 2, "R4");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule